// File: doc/BRIEF.md
# Occupancy Light Controller

This block runs the lights of a meeting room from a motion detector. It counts whole seconds through a one-cycle tick enable. While nobody moves, it counts idle time. After a first idle limit it switches the lights off. After a second, longer limit it issues a single strobe that returns the room's light scene to its default settings. Any motion switches the lights back on at once and restarts the idle count from zero.

The motion detector also sends a periodic heartbeat. A watchdog counts the ticks since the last heartbeat. If a whole window of ticks passes without one, the controller raises a sensor-failure flag. While that flag is set, the controller does not switch the lights off on its own, because a silent detector cannot be trusted to report an empty room.

The three limits are parameters. A simulation can therefore use short windows while the chip keeps the one-second values.

Top module: `occ_light_ctrl`

## Requirements
- R1: While reset is held and on its release, `lights_on` is 1, `sensor_fail` is 0 and `scene_rst` is 0.
- R2: A cycle with `motion` high sets `lights_on` to 1 at the next clock edge.
- R3: Once LIGHT_IDLE_TICKS ticks (default 150) have passed with `motion` low, `lights_on` drops to 0 one clock after the edge that takes the last of those ticks, provided `sensor_fail` is 0.
- R4: While `sensor_fail` is 1, `lights_on` is not cleared by the idle timeout. If the flag later clears and the room is still idle, the lights go off one clock after the flag clears.
- R5: Once SCENE_IDLE_TICKS ticks (default 300) have passed with `motion` low, `scene_rst` is 1 for exactly one cycle. That cycle starts one clock after the edge that takes the last tick.
- R6: After a `scene_rst` pulse, no further pulse occurs until `motion` has been high at least once. After that motion, a new full idle period produces a new pulse.
- R7: `motion` high clears both idle counts. Each timeout then needs its full number of idle ticks again, counted from the end of the motion.
- R8: When BEAT_WINDOW_TICKS ticks (default 60) pass with `heartbeat` low, `sensor_fail` becomes 1 at the edge that takes the last of those ticks. After fewer ticks it stays 0.
- R9: A cycle with `heartbeat` high clears `sensor_fail` at the next edge and restarts the heartbeat window from zero.
- R10: Clock cycles without `tick` do not advance any count. Any number of them leaves the outputs unchanged when `motion` and `heartbeat` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable, one per second |
| motion | input | 1 | Motion detected (level) |
| heartbeat | input | 1 | Detector alive pulse |
| lights_on | output | 1 | Lights switched on |
| scene_rst | output | 1 | One-cycle default-scene restore strobe |
| sensor_fail | output | 1 | Detector heartbeat lost |

## Verification
The heartbeat flag is set or cleared at the same edge that takes the deciding tick or heartbeat. The lights and the scene strobe pass through one more register, so they change one clock after the edge that takes the final idle tick. Motion sets the lights at the very next edge. The bench drives every input just after a falling edge and reads the outputs at the following falling edge. Each check after a final tick therefore adds exactly one idle cycle for the lights and the strobe and none for the flag. It also checks the cycle just before each limit, so an off-by-one count shows up.

// File: rtl/occ_pkg.sv
package occ_pkg;

   localparam int unsigned NUM_IDLE_TMR = 2;

   typedef enum int unsigned {
      TMR_LIGHT = 0,
      TMR_SCENE = 1
   } idle_tmr_e;

   function automatic int unsigned cnt_bits(input int unsigned lim);
      return (lim < 1) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/occ_idle_timer.sv
module occ_idle_timer #(
   parameter int unsigned LIMIT = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   output logic expired
);
   localparam int unsigned W = occ_pkg::cnt_bits(LIMIT);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("occ_idle_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clear)                 cnt_q <= '0;
      else if (tick && cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIM_V);

   p_clear_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !expired);

   p_no_tick_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/occ_hb_watchdog.sv
module occ_hb_watchdog #(
   parameter int unsigned WINDOW = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic heartbeat,
   output logic fail
);
   localparam int unsigned W = occ_pkg::cnt_bits(WINDOW);
   localparam logic [W-1:0] LAST_V = W'(WINDOW - 1);
   localparam logic [W-1:0] SAT_V  = W'(WINDOW);

   generate
      if (WINDOW < 1) begin : g_bad_window
         $error("occ_hb_watchdog: WINDOW must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic         fail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else if (heartbeat) begin
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else if (tick) begin
         if (cnt_q == LAST_V) fail_q <= 1'b1;
         if (cnt_q != SAT_V)  cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign fail = fail_q;

   p_beat_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      heartbeat |=> !fail);

   p_fail_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> ($past(tick) && !$past(heartbeat)));

endmodule

// File: rtl/occ_out_ctrl.sv
module occ_out_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic motion,
   input  logic fail,
   input  logic light_exp,
   input  logic scene_exp,
   output logic lights_on,
   output logic scene_rst
);
   logic lights_q;
   logic armed_q;
   logic scene_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    lights_q <= 1'b1;
      else if (motion)               lights_q <= 1'b1;
      else if (light_exp && !fail)   lights_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         scene_q <= 1'b0;
      end else begin
         scene_q <= !motion && scene_exp && armed_q;
         if (motion)         armed_q <= 1'b1;
         else if (scene_exp) armed_q <= 1'b0;
      end
   end

   assign lights_on = lights_q;
   assign scene_rst = scene_q;

   p_motion_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
      motion |=> lights_on);

   p_fail_keeps_lights_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lights_on && fail) |=> lights_on);

   p_scene_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scene_rst |=> !scene_rst);

   p_scene_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scene_rst |-> !$past(motion));

endmodule

// File: rtl/occ_light_ctrl.sv
module occ_light_ctrl #(
   parameter int unsigned LIGHT_IDLE_TICKS  = 150,
   parameter int unsigned SCENE_IDLE_TICKS  = 300,
   parameter int unsigned BEAT_WINDOW_TICKS = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic motion,
   input  logic heartbeat,
   output logic lights_on,
   output logic scene_rst,
   output logic sensor_fail
);
   import occ_pkg::*;

   localparam int unsigned TMR_LIMIT [NUM_IDLE_TMR] = '{LIGHT_IDLE_TICKS, SCENE_IDLE_TICKS};

   logic [NUM_IDLE_TMR-1:0] exp_vec;
   logic                    fail_w;

   generate
      for (genvar g = 0; g < NUM_IDLE_TMR; g++) begin : g_idle
         occ_idle_timer #(.LIMIT(TMR_LIMIT[g])) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .clear   (motion),
            .expired (exp_vec[g])
         );
      end
   endgenerate

   occ_hb_watchdog #(.WINDOW(BEAT_WINDOW_TICKS)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .heartbeat (heartbeat),
      .fail      (fail_w)
   );

   occ_out_ctrl u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .motion    (motion),
      .fail      (fail_w),
      .light_exp (exp_vec[TMR_LIGHT]),
      .scene_exp (exp_vec[TMR_SCENE]),
      .lights_on (lights_on),
      .scene_rst (scene_rst)
   );

   assign sensor_fail = fail_w;

   p_reset_values_r1: assert property (@(posedge clk)
      !rst_n |=> (lights_on && !sensor_fail && !scene_rst));

endmodule

// File: tb/occ_light_ctrl_bench.sv
`timescale 1ns/1ps
module occ_light_ctrl_bench;
   localparam int unsigned LT = 6;
   localparam int unsigned ST = 11;
   localparam int unsigned HB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, motion = 1'b0, heartbeat = 1'b0;
   logic lights_on, scene_rst, sensor_fail;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   occ_light_ctrl #(.LIGHT_IDLE_TICKS(LT), .SCENE_IDLE_TICKS(ST), .BEAT_WINDOW_TICKS(HB)) u_occ_light_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .motion(motion), .heartbeat(heartbeat),
      .lights_on(lights_on), .scene_rst(scene_rst), .sensor_fail(sensor_fail));

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: inputs set after a falling edge, outputs read at the next one
   task automatic step(input logic m, input logic t, input logic h);
      motion = m; tick = t; heartbeat = h;
      @(negedge clk);
      motion = 1'b0; tick = 1'b0; heartbeat = 1'b0;
   endtask

   task automatic ticks(input int n, input logic h);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, h);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 lights", lights_on, 1'b1);
      check("R1 fail", sensor_fail, 1'b0);
      check("R1 scene", scene_rst, 1'b0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0);
      check("R1 lights after release", lights_on, 1'b1);
   endtask

   task automatic t_light_off();
      step(1'b1, 1'b0, 1'b1);
      repeat (50) step(1'b0, 1'b0, 1'b0);
      check("R10 no tick keeps lights", lights_on, 1'b1);
      check("R10 no tick keeps fail", sensor_fail, 1'b0);
      ticks(LT - 1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R3 before limit", lights_on, 1'b1);
      ticks(1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R3 lights off", lights_on, 1'b0);
   endtask

   task automatic t_motion_on();
      step(1'b1, 1'b0, 1'b1);
      check("R2 motion relights", lights_on, 1'b1);
   endtask

   task automatic t_cancel();
      step(1'b1, 1'b0, 1'b1);
      ticks(LT - 1, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      ticks(LT - 1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R7 motion restarts idle", lights_on, 1'b1);
      ticks(1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R7 off after full period", lights_on, 1'b0);
   endtask

   task automatic t_scene();
      step(1'b1, 1'b0, 1'b1);
      ticks(ST - 1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R5 no pulse before limit", scene_rst, 1'b0);
      ticks(1, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R5 pulse", scene_rst, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R5 pulse one cycle", scene_rst, 1'b0);
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 3 * ST; i++) begin
            step(1'b0, 1'b1, 1'b1);
            if (scene_rst) seen = 1'b1;
         end
         check("R6 no repeat without motion", seen, 1'b0);
      end
      step(1'b1, 1'b0, 1'b1);
      ticks(ST, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      check("R6 rearmed by motion", scene_rst, 1'b1);
   endtask

   task automatic t_fail();
      step(1'b1, 1'b0, 1'b1);
      ticks(HB - 1, 1'b0);
      check("R8 no fail before window", sensor_fail, 1'b0);
      ticks(1, 1'b0);
      check("R8 fail raised", sensor_fail, 1'b1);
      ticks(LT, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check("R4 lights held in failure", lights_on, 1'b1);
      check("R8 fail stays", sensor_fail, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      check("R9 beat clears fail", sensor_fail, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check("R4 lights off after recovery", lights_on, 1'b0);
      ticks(HB - 1, 1'b0);
      check("R9 window restarted", sensor_fail, 1'b0);
      ticks(1, 1'b0);
      check("R9 fail after new window", sensor_fail, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_light_off();
      t_motion_on();
      t_cancel();
      t_scene();
      t_fail();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule